// File: doc/BRIEF.md
# Mode-Dependent SPI Register Access Decoder

This block is the register access unit on the serial side of a system basis controller. Each serial frame carries a four-bit header and a twelve-bit data word. The header holds a two-bit register slot, a bit that chooses which of the two feedback words for that slot is returned, and a read-only flag. While the frame is still being clocked in, the decoder shifts the chosen feedback word back out. When the frame ends, it commits the data word to a register. Which register receives it depends on the slot and on the current operating mode.

Writes to the mode register are screened. The watchdog-period field and the requested-mode field must each hold a value from a parameterised legal set. An illegal value discards the write and raises a one-cycle system reset request. After the external reset line is released, a legal mode-register write must arrive within a bounded number of clock cycles, or a reset request is raised. The bit-level shifter and the operating-mode state machine sit outside this block. It receives per-bit strobes, frame start and end strobes, the operating mode and the reset-line level.

Top module: `sbc_spi_regdec`

## Requirements
- R1: A frame is 16 bits, most significant first, one bit per clock where `bit_vld` is high. The first bit is slot bit 1, then slot bit 0, then the feedback-select bit, then the read-only bit, then data bits 11 down to 0.
- R2: A register is updated only in the clock cycle where `frm_done` is sampled, and only if exactly 16 `bit_vld` strobes were seen since the last `frm_start`. A frame of any other length changes no register.
- R3: When the read-only bit is 1, no register changes.
- R4: `miso` is 0 during the header. Once the fourth header bit is taken, `miso` presents the selected 12-bit feedback word, most significant bit first, advancing one bit per `bit_vld`. The feedback words, with select=0 / select=1, are:
  - slot 00: `stat_in` / `diag_in`
  - slot 01: interrupt enable / (`irq_in` in Normal and Standby, otherwise special mode)
  - slot 10: system configuration / general purpose 0
  - slot 11: physical layer control / general purpose 1
- R5: Slot 00 writes the mode register in every operating mode, including undefined codes, when the code is legal.
- R6: Operating-mode codes are Start-up=1, Restart=2, Standby=3, Normal=4, Flash=5. Slot 01 writes interrupt enable in Normal and Standby, and special mode in Start-up, Restart and Flash.
- R7: Slot 10 writes general purpose 0 in Normal and Standby, and system configuration in Start-up, Restart and Flash.
- R8: Slot 11 writes physical layer control in Normal, and general purpose 1 in Standby, Start-up, Restart and Flash.
- R9: Under an undefined operating-mode code (0, 6, 7), slots 01, 10 and 11 write nothing.
- R10: The mode-register word has its watchdog field in bits 11:9 and its requested-mode field in bits 8:6. If either field is outside its legal set, the write is discarded and `rst_req` is high for one cycle, in the cycle after the `frm_done` edge.
- R11: Suppose `rstout_hi` is sampled high on INIT_WIN consecutive edges and no legal mode write commits on any of them. Then `rst_req` pulses once after the last of those edges, and the window stays closed until `rstout_hi` is low again. Writes committed while `rstout_hi` is low do not close the window.
- R12: After reset, all registers, `miso` and `rst_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | Current operating mode code |
| rstout_hi | input | 1 | External reset line released (high) |
| frm_start | input | 1 | Frame start strobe |
| bit_vld | input | 1 | Serial bit strobe |
| bit_in | input | 1 | Serial input bit |
| frm_done | input | 1 | Frame end strobe |
| stat_in | input | 12 | System status feedback word |
| diag_in | input | 12 | System diagnosis feedback word |
| irq_in | input | 12 | Interrupt flags feedback word |
| miso | output | 1 | Serial feedback bit |
| mode_q | output | 12 | Mode register |
| inten_q | output | 12 | Interrupt enable register |
| specmode_q | output | 12 | Special mode register |
| syscfg_q | output | 12 | System configuration register |
| gp0_q | output | 12 | General purpose register 0 |
| gp1_q | output | 12 | General purpose register 1 |
| phyctl_q | output | 12 | Physical layer control register |
| rst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with INIT_WIN set to 40 instead of the default 256. The start-up window can then expire within a short run, and a legal write can still be placed inside it with a single frame of about 36 cycles. The legal masks keep their defaults: watchdog codes 0 to 3 and requested-mode codes 3 to 5. This puts both a watchdog-field violation and a mode-field violation within reach with hand-picked words.

// File: rtl/sbc_regdec_pkg.sv
package sbc_regdec_pkg;

  localparam int AW = 2;
  localparam int HW = AW + 2;

  localparam logic [2:0] OPM_STARTUP = 3'd1;
  localparam logic [2:0] OPM_RESTART = 3'd2;
  localparam logic [2:0] OPM_STANDBY = 3'd3;
  localparam logic [2:0] OPM_NORMAL  = 3'd4;
  localparam logic [2:0] OPM_FLASH   = 3'd5;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_MODE  = 3'd1,
    TGT_INTEN = 3'd2,
    TGT_SPEC  = 3'd3,
    TGT_CFG   = 3'd4,
    TGT_GP0   = 3'd5,
    TGT_GP1   = 3'd6,
    TGT_PHY   = 3'd7
  } tgt_e;

  localparam int N_TGT = 8;

  function automatic logic opm_awake(input logic [2:0] opm);
    return (opm == OPM_NORMAL) || (opm == OPM_STANDBY);
  endfunction

  function automatic logic opm_boot(input logic [2:0] opm);
    return (opm == OPM_STARTUP) || (opm == OPM_RESTART) || (opm == OPM_FLASH);
  endfunction

  function automatic tgt_e wr_target(input logic [AW-1:0] slot, input logic [2:0] opm);
    tgt_e t;
    t = TGT_NONE;
    case (slot)
      2'b00: t = TGT_MODE;
      2'b01: begin
        if (opm_awake(opm))     t = TGT_INTEN;
        else if (opm_boot(opm)) t = TGT_SPEC;
      end
      2'b10: begin
        if (opm_awake(opm))     t = TGT_GP0;
        else if (opm_boot(opm)) t = TGT_CFG;
      end
      default: begin
        if (opm == OPM_NORMAL)                               t = TGT_PHY;
        else if (opm == OPM_STANDBY || opm_boot(opm))        t = TGT_GP1;
      end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sbc_frame_rx.sv
module sbc_frame_rx
  import sbc_regdec_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_start,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic          frm_done,
  input  logic [DW-1:0] fb_word,
  output logic [AW-1:0] rd_addr,
  output logic          rd_rrs,
  output logic          cmt_vld,
  output logic [AW-1:0] cmt_addr,
  output logic          cmt_ro,
  output logic [DW-1:0] cmt_data,
  output logic          miso
);

  localparam int FRAME = HW + DW;
  localparam int CW    = $clog2(FRAME + 2);
  localparam logic [CW-1:0] NB_FULL = CW'(FRAME);
  localparam logic [CW-1:0] NB_SAT  = CW'(FRAME + 1);
  localparam logic [CW-1:0] NB_HDR  = CW'(HW);

  logic [CW-1:0]    nb;
  logic [FRAME-1:0] rx;
  logic [DW-1:0]    tx;
  logic             hdr_load;
  logic             unused_rrs;

  // after HW-1 bits, rx holds slot and select; the incoming bit is RO
  assign rd_addr  = rx[HW-2 -: AW];
  assign rd_rrs   = rx[0];
  assign hdr_load = bit_vld && (nb == NB_HDR - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || frm_start) begin
      nb <= '0;
      rx <= '0;
      tx <= '0;
    end else if (bit_vld) begin
      rx <= {rx[FRAME-2:0], bit_in};
      if (nb != NB_SAT) nb <= nb + 1'b1;
      if (hdr_load)          tx <= fb_word;
      else if (nb >= NB_HDR) tx <= {tx[DW-2:0], 1'b0};
    end
  end

  assign miso       = tx[DW-1];
  assign cmt_vld    = frm_done && (nb == NB_FULL);
  assign cmt_addr   = rx[FRAME-1 -: AW];
  assign cmt_ro     = rx[DW];
  assign cmt_data   = rx[DW-1:0];
  assign unused_rrs = rx[DW+1];

  AST_HDR_SILENT: assert property (@(posedge clk) disable iff (rst)
    (frm_start) |=> !miso) else $error("header not silent"); // R4

endmodule

// File: rtl/sbc_mode_guard.sv
module sbc_mode_guard
  import sbc_regdec_pkg::*;
#(
  parameter int DW       = 12,
  parameter int INIT_WIN = 256,
  parameter int WD_LSB   = 9,
  parameter int WD_W     = 3,
  parameter int MD_LSB   = 6,
  parameter int MD_W     = 3,
  parameter logic [(1<<WD_W)-1:0] WD_MASK = 8'h0F,
  parameter logic [(1<<MD_W)-1:0] MD_MASK = 8'h38
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rstout_hi,
  input  logic          cmt_vld,
  input  logic          cmt_ro,
  input  logic [AW-1:0] cmt_addr,
  input  logic [DW-1:0] cmt_data,
  output logic          mode_wr_ok,
  output logic          rst_req
);

  localparam int TW = $clog2(INIT_WIN + 1);
  localparam logic [TW-1:0] T_LAST = TW'(INIT_WIN - 1);

  logic          wd_ok, md_ok, mode_cmt, mode_bad, tmo;
  logic          pend;
  logic [TW-1:0] cnt;
  logic          unused_data;

  assign wd_ok       = WD_MASK[cmt_data[WD_LSB +: WD_W]];
  assign md_ok       = MD_MASK[cmt_data[MD_LSB +: MD_W]];
  assign mode_cmt    = cmt_vld && !cmt_ro && (cmt_addr == '0);
  assign mode_wr_ok  = mode_cmt && wd_ok && md_ok;
  assign mode_bad    = mode_cmt && !(wd_ok && md_ok);
  assign tmo         = rstout_hi && pend && !mode_wr_ok && (cnt == T_LAST);
  assign unused_data = ^cmt_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b1;
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= mode_bad || tmo;
      if (!rstout_hi) begin
        pend <= 1'b1;
        cnt  <= '0;
      end else if (pend) begin
        if (mode_wr_ok)        pend <= 1'b0;
        else if (cnt == T_LAST) pend <= 1'b0;
        else                   cnt  <= cnt + 1'b1;
      end
    end
  end

  AST_ILLEGAL_RAISES: assert property (@(posedge clk) disable iff (rst)
    (cmt_vld && !cmt_ro && cmt_addr == '0 &&
     !(WD_MASK[cmt_data[WD_LSB +: WD_W]] && MD_MASK[cmt_data[MD_LSB +: MD_W]]))
    |=> rst_req) else $error("illegal code without reset request"); // R10

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    pend |-> (cnt <= T_LAST)) else $error("window counter overrun"); // R11

endmodule

// File: rtl/sbc_reg_bank.sv
module sbc_reg_bank
  import sbc_regdec_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_mode,
  input  logic          cmt_vld,
  input  logic          cmt_ro,
  input  logic [AW-1:0] cmt_addr,
  input  logic [DW-1:0] cmt_data,
  input  logic          mode_wr_ok,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_rrs,
  input  logic [DW-1:0] stat_in,
  input  logic [DW-1:0] diag_in,
  input  logic [DW-1:0] irq_in,
  output logic [DW-1:0] fb_word,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] inten_q,
  output logic [DW-1:0] specmode_q,
  output logic [DW-1:0] syscfg_q,
  output logic [DW-1:0] gp0_q,
  output logic [DW-1:0] gp1_q,
  output logic [DW-1:0] phyctl_q
);

  tgt_e          tgt;
  logic          wr_en;
  logic [DW-1:0] rf [N_TGT];

  assign tgt   = wr_target(cmt_addr, op_mode);
  assign wr_en = cmt_vld && !cmt_ro && (tgt != TGT_NONE) &&
                 ((tgt != TGT_MODE) || mode_wr_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_TGT; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[tgt] <= cmt_data;
    end
  end

  assign mode_q     = rf[TGT_MODE];
  assign inten_q    = rf[TGT_INTEN];
  assign specmode_q = rf[TGT_SPEC];
  assign syscfg_q   = rf[TGT_CFG];
  assign gp0_q      = rf[TGT_GP0];
  assign gp1_q      = rf[TGT_GP1];
  assign phyctl_q   = rf[TGT_PHY];

  always_comb begin
    case (rd_addr)
      2'b00:   fb_word = rd_rrs ? diag_in : stat_in;
      2'b01:   fb_word = rd_rrs ? (opm_awake(op_mode) ? irq_in : rf[TGT_SPEC])
                                : rf[TGT_INTEN];
      2'b10:   fb_word = rd_rrs ? rf[TGT_GP0] : rf[TGT_CFG];
      default: fb_word = rd_rrs ? rf[TGT_GP1] : rf[TGT_PHY];
    endcase
  end

  AST_RO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cmt_vld && cmt_ro) |=> ($stable(mode_q) && $stable(inten_q) && $stable(specmode_q) &&
                             $stable(syscfg_q) && $stable(gp0_q) && $stable(gp1_q) &&
                             $stable(phyctl_q))) else $error("read-only frame wrote"); // R3

  AST_MODE_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
    mode_wr_ok |=> (mode_q == $past(cmt_data))) else $error("mode write lost"); // R5

  AST_NORMAL_SPARES_GP1: assert property (@(posedge clk) disable iff (rst)
    (cmt_vld && !cmt_ro && cmt_addr == 2'b11 && op_mode == OPM_NORMAL) |=> $stable(gp1_q))
    else $error("slot 11 in Normal hit gp1"); // R8

endmodule

// File: rtl/sbc_spi_regdec.sv
module sbc_spi_regdec
  import sbc_regdec_pkg::*;
#(
  parameter int DW       = 12,
  parameter int INIT_WIN = 256,
  parameter int WD_LSB   = 9,
  parameter int WD_W     = 3,
  parameter int MD_LSB   = 6,
  parameter int MD_W     = 3,
  parameter logic [(1<<WD_W)-1:0] WD_MASK = 8'h0F,
  parameter logic [(1<<MD_W)-1:0] MD_MASK = 8'h38
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_mode,
  input  logic          rstout_hi,
  input  logic          frm_start,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic          frm_done,
  input  logic [DW-1:0] stat_in,
  input  logic [DW-1:0] diag_in,
  input  logic [DW-1:0] irq_in,
  output logic          miso,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] inten_q,
  output logic [DW-1:0] specmode_q,
  output logic [DW-1:0] syscfg_q,
  output logic [DW-1:0] gp0_q,
  output logic [DW-1:0] gp1_q,
  output logic [DW-1:0] phyctl_q,
  output logic          rst_req
);

  logic [DW-1:0] fb_word;
  logic [AW-1:0] rd_addr, cmt_addr;
  logic          rd_rrs, cmt_vld, cmt_ro, mode_wr_ok;
  logic [DW-1:0] cmt_data;

  sbc_frame_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .frm_start(frm_start), .bit_vld(bit_vld), .bit_in(bit_in),
    .frm_done(frm_done), .fb_word(fb_word), .rd_addr(rd_addr), .rd_rrs(rd_rrs),
    .cmt_vld(cmt_vld), .cmt_addr(cmt_addr), .cmt_ro(cmt_ro), .cmt_data(cmt_data),
    .miso(miso)
  );

  sbc_mode_guard #(
    .DW(DW), .INIT_WIN(INIT_WIN), .WD_LSB(WD_LSB), .WD_W(WD_W),
    .MD_LSB(MD_LSB), .MD_W(MD_W), .WD_MASK(WD_MASK), .MD_MASK(MD_MASK)
  ) u_guard (
    .clk(clk), .rst(rst), .rstout_hi(rstout_hi), .cmt_vld(cmt_vld), .cmt_ro(cmt_ro),
    .cmt_addr(cmt_addr), .cmt_data(cmt_data), .mode_wr_ok(mode_wr_ok), .rst_req(rst_req)
  );

  sbc_reg_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst(rst), .op_mode(op_mode), .cmt_vld(cmt_vld), .cmt_ro(cmt_ro),
    .cmt_addr(cmt_addr), .cmt_data(cmt_data), .mode_wr_ok(mode_wr_ok),
    .rd_addr(rd_addr), .rd_rrs(rd_rrs), .stat_in(stat_in), .diag_in(diag_in),
    .irq_in(irq_in), .fb_word(fb_word), .mode_q(mode_q), .inten_q(inten_q),
    .specmode_q(specmode_q), .syscfg_q(syscfg_q), .gp0_q(gp0_q), .gp1_q(gp1_q),
    .phyctl_q(phyctl_q)
  );

  AST_BAD_LENGTH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !cmt_vld) |=> ($stable(mode_q) && $stable(inten_q) && $stable(specmode_q) &&
                                $stable(syscfg_q) && $stable(gp0_q) && $stable(gp1_q) &&
                                $stable(phyctl_q))) else $error("bad-length frame wrote"); // R2

endmodule

// File: tb/sbc_spi_regdec_bench.sv
module sbc_spi_regdec_bench;

  localparam int W = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_mode = 3'd4;
  logic        rstout_hi = 1'b0;
  logic        frm_start = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, frm_done = 1'b0;
  logic [11:0] stat_in = 12'h3C5, diag_in = 12'h9A6, irq_in = 12'h5E1;
  logic        miso, rst_req;
  logic [11:0] mode_q, inten_q, specmode_q, syscfg_q, gp0_q, gp1_q, phyctl_q;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  sbc_spi_regdec #(.INIT_WIN(W), .WD_MASK(8'h0F), .MD_MASK(8'h38)) u_sbc_spi_regdec (
    .clk(clk), .rst(rst), .op_mode(op_mode), .rstout_hi(rstout_hi), .frm_start(frm_start),
    .bit_vld(bit_vld), .bit_in(bit_in), .frm_done(frm_done), .stat_in(stat_in),
    .diag_in(diag_in), .irq_in(irq_in), .miso(miso), .mode_q(mode_q), .inten_q(inten_q),
    .specmode_q(specmode_q), .syscfg_q(syscfg_q), .gp0_q(gp0_q), .gp1_q(gp1_q),
    .phyctl_q(phyctl_q), .rst_req(rst_req)
  );

  // ---------------- behavioural reference model ----------------
  int          m_nb;
  logic [15:0] m_rx;
  logic [11:0] m_tx;
  logic [11:0] m_reg [string];
  bit          m_pend, m_rr;
  int          m_cnt;

  function automatic bit legal(input logic [11:0] d);
    return (d[11:9] <= 3) && (d[8:6] >= 3) && (d[8:6] <= 5);
  endfunction
  function automatic bit awake(input logic [2:0] o); return o == 3 || o == 4; endfunction
  function automatic bit boot(input logic [2:0] o);  return o == 1 || o == 2 || o == 5; endfunction

  function automatic logic [11:0] fb(input int a, input bit s);
    case (a)
      0: return s ? diag_in : stat_in;
      1: return s ? (awake(op_mode) ? irq_in : m_reg["spec"]) : m_reg["inten"];
      2: return s ? m_reg["gp0"] : m_reg["cfg"];
      default: return s ? m_reg["gp1"] : m_reg["phy"];
    endcase
  endfunction

  task automatic model_reset();
    m_nb = 0; m_rx = '0; m_tx = '0; m_pend = 1; m_cnt = 0; m_rr = 0;
    foreach (m_reg[k]) m_reg[k] = '0;
  endtask

  initial begin
    m_reg["mode"] = 0; m_reg["inten"] = 0; m_reg["spec"] = 0; m_reg["cfg"] = 0;
    m_reg["gp0"] = 0; m_reg["gp1"] = 0; m_reg["phy"] = 0;
    model_reset();
  end

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      bit lw; bit rr; logic [11:0] d;
      lw = 0; rr = 0;
      if (frm_done && m_nb == 16 && !m_rx[12]) begin
        d = m_rx[11:0];
        case (m_rx[15:14])
          2'd0: if (legal(d)) begin m_reg["mode"] = d; lw = 1; end else rr = 1;
          2'd1: if (awake(op_mode)) m_reg["inten"] = d; else if (boot(op_mode)) m_reg["spec"] = d;
          2'd2: if (awake(op_mode)) m_reg["gp0"] = d;   else if (boot(op_mode)) m_reg["cfg"] = d;
          default: if (op_mode == 4) m_reg["phy"] = d;
                   else if (op_mode == 3 || boot(op_mode)) m_reg["gp1"] = d;
        endcase
      end
      if (!rstout_hi) begin m_pend = 1; m_cnt = 0; end
      else if (m_pend) begin
        if (lw) m_pend = 0;
        else if (m_cnt == W - 1) begin m_pend = 0; rr = 1; end
        else m_cnt++;
      end
      m_rr = rr;
      if (frm_start) begin m_nb = 0; m_rx = '0; m_tx = '0; end
      else if (bit_vld) begin
        if (m_nb == 3) m_tx = fb(int'(m_rx[2:1]), m_rx[0]);
        else if (m_nb >= 4) m_tx = m_tx << 1;
        m_rx = {m_rx[14:0], bit_in};
        if (m_nb < 17) m_nb++;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_req === 1'b1) pulses++;
    if (cmp_on) begin
      chk("R4 miso",      miso,       m_tx[11]);
      chk("R10 rst_req",  rst_req,    m_rr);
      chk("R5 mode_q",    mode_q,     m_reg["mode"]);
      chk("R6 inten_q",   inten_q,    m_reg["inten"]);
      chk("R6 specmode",  specmode_q, m_reg["spec"]);
      chk("R7 syscfg_q",  syscfg_q,   m_reg["cfg"]);
      chk("R7 gp0_q",     gp0_q,      m_reg["gp0"]);
      chk("R8 gp1_q",     gp1_q,      m_reg["gp1"]);
      chk("R8 phyctl_q",  phyctl_q,   m_reg["phy"]);
    end
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // R1: bits go out most significant first
  task automatic send(input logic [15:0] w, input int nbits, output logic [11:0] rd);
    rd = '0;
    @(negedge clk); frm_start = 1;
    @(negedge clk); frm_start = 0;
    for (int i = 0; i < nbits; i++) begin
      if (i >= 4 && i < 16) rd[15-i] = miso;
      bit_vld = 1; bit_in = (i < 16) ? w[15-i] : 1'b0;
      @(negedge clk); bit_vld = 0; bit_in = 0;
      @(negedge clk);
    end
    frm_done = 1;
    @(negedge clk); frm_done = 0;
  endtask

  initial begin
    logic [11:0] rd;
    int p0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 reset miso", miso, 0);
    chk("R12 reset rst_req", rst_req, 0);
    chk("R12 reset regs", {mode_q, inten_q, gp1_q, phyctl_q}, 0);
    cmp_on = 1;

    rstout_hi = 1;
    send(16'h0515, 16, rd);                 chk("R5 mode write", mode_q, 12'h515);
    op_mode = 3'd4;
    send(16'h4A5C, 16, rd);                 chk("R6 normal slot01", inten_q, 12'hA5C);
    send(16'h83C3, 16, rd);                 chk("R7 normal slot10", gp0_q, 12'h3C3);
    send(16'hC0F0, 16, rd);                 chk("R8 normal slot11", phyctl_q, 12'h0F0);
    chk("R8 normal spares gp1", gp1_q, 12'h000);
    op_mode = 3'd3;
    send(16'hC777, 16, rd);                 chk("R8 standby slot11", gp1_q, 12'h777);
    op_mode = 3'd1;
    send(16'h4123, 16, rd);                 chk("R6 startup slot01", specmode_q, 12'h123);
    send(16'h8456, 16, rd);                 chk("R7 startup slot10", syscfg_q, 12'h456);

    send(16'h7FFF, 16, rd);                 chk("R4 read spec", rd, 12'h123);
    chk("R3 read-only no write", specmode_q, 12'h123);
    send(16'h9FFF, 16, rd);                 chk("R4 read cfg", rd, 12'h456);
    chk("R3 read-only cfg kept", syscfg_q, 12'h456);
    send(16'h3000, 16, rd);                 chk("R4 read diag", rd, 12'h9A6);
    op_mode = 3'd4;
    send(16'h7000, 16, rd);                 chk("R4 read irq normal", rd, 12'h5E1);
    send(16'hD000, 16, rd);                 chk("R4 read phy", rd, 12'h0F0);

    send(16'h4FFF, 15, rd);                 chk("R2 short frame", inten_q, 12'hA5C);
    send(16'h4FFF, 17, rd);                 chk("R2 long frame", inten_q, 12'hA5C);

    send(16'h0200, 16, rd);
    chk("R10 bad mode field pulse", rst_req, 1);
    chk("R10 bad mode discarded", mode_q, 12'h515);
    send(16'h0F00, 16, rd);
    chk("R10 bad watchdog pulse", rst_req, 1);
    @(negedge clk);                         chk("R10 pulse one cycle", rst_req, 0);

    op_mode = 3'd7;
    send(16'h4EEE, 16, rd);                 chk("R9 undefined slot01", inten_q, 12'hA5C);
    send(16'h8EEE, 16, rd);                 chk("R9 undefined slot10", gp0_q, 12'h3C3);
    send(16'h00C0, 16, rd);                 chk("R9 slot00 still writes", mode_q, 12'h0C0);

    rstout_hi = 0; repeat (3) @(negedge clk);
    p0 = pulses; rstout_hi = 1;
    repeat (W + 10) @(negedge clk);
    chk("R11 window expiry pulses", pulses - p0, 1);

    rstout_hi = 0; repeat (3) @(negedge clk);
    p0 = pulses; rstout_hi = 1;
    send(16'h0515, 16, rd);
    repeat (W + 10) @(negedge clk);
    chk("R11 legal write closes window", pulses - p0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule